// File: doc/BRIEF.md
# Strided Gather/Scatter Lane Memory Port

This block is the access port of a small on-chip vertex store that feeds a 16-lane SIMD datapath with 32-bit lanes. A vector read gathers one word for every lane from locations spaced a programmable stride apart, starting at a shared base pointer. A vector write scatters the lane values to the same pattern of locations. After every executed access the base pointer moves forward by a separate programmable step. Because of this, a program can walk through attribute after attribute of a batch of 16 records without recomputing addresses.

The store is modelled inside the block as a word array. Software sets base, stride and step through a single-cycle setup strobe. Reads return a full 16-lane vector one cycle after they execute, marked by a valid strobe. Writes have priority. A read requested in the same cycle as a write is held for one cycle and then executes at the pointer the write left behind. The requester must not raise a new read while such a held read is still outstanding.

Top module: `lane_stride_mem`

## Requirements
- R1: An executed read returns, in lane i (bits 32*i+31 down to 32*i of `rd_data`), the word stored at address base + i*stride, for i = 0..15.
- R2: An executed write stores lane i of `wr_data` (bits 32*i+31 down to 32*i) at address base + i*stride. When several lanes map to the same address, the highest-numbered of those lanes is the one stored.
- R3: Each executed read or write advances the base pointer by the step value. Stride and step are left unchanged.
- R4: A setup strobe loads base, stride and step, and these values govern the next access. An access in the same cycle as the strobe uses the previous settings, and the loaded base replaces that access's pointer advance.
- R5: `rd_valid` is high in exactly the cycle after a read executes, with the gathered data on `rd_data`. In every other cycle `rd_valid` is low and `rd_data` holds its last value. A read observes all writes from earlier cycles.
- R6: When read and write are requested together, the write executes in that cycle. The read stays pending and executes in the first later cycle without a write request, at the advanced pointer.
- R7: After reset, base, stride and step are zero, `rd_valid` is low and `rd_data` is zero.
- R8: All address arithmetic wraps modulo the memory depth (256 words by default, which must be a power of two).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Setup strobe: load base, stride and step |
| cfg_base | input | ADDR_W | Base pointer value to load |
| cfg_stride | input | ADDR_W | Lane-to-lane address spacing to load |
| cfg_step | input | ADDR_W | Pointer advance per access to load |
| rd_req | input | 1 | Vector read request |
| wr_req | input | 1 | Vector write request |
| wr_data | input | LANES*WORD_W | Lane values to scatter, lane 0 in the low bits |
| rd_data | output | LANES*WORD_W | Gathered lane values, lane 0 in the low bits |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
A read that executes in its own cycle shows `rd_valid` and its data on the next clock edge. A read that collides with a write executes one or more cycles later, depending on how many back-to-back writes follow, and its data appears on the edge after it executes. Writes and pointer moves only become visible through later reads. The bench drives every input on the falling edge and updates its own memory and pointer model for that cycle. It checks the outputs on the following falling edge, after exactly one register stage. A fixed-seed random phase mixes setups, reads, writes and collisions, and follows directed cases for lane collisions, wrap-around, setup during access and held reads.

// File: rtl/lane_stride_pkg.sv
package lane_stride_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lane_op_e;
endpackage

// File: rtl/lane_stride_arb.sv
module lane_stride_arb
  import lane_stride_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_req,
  input  logic     wr_req,
  output lane_op_e op
);
  logic held_q;
  logic rd_want;

  assign rd_want = rd_req | held_q;

  always_comb begin
    if (wr_req)       op = OP_WRITE;
    else if (rd_want) op = OP_READ;
    else              op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= rd_want & wr_req;
  end

  // R6: a read that lost to a write is served once the write traffic stops
  assert_held_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_req) |=> (wr_req || op == OP_READ));

  // R6: a write request always wins the cycle
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && rd_req) |-> op != OP_READ);
endmodule

// File: rtl/lane_stride_addr.sv
module lane_stride_addr #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_load,
  input  logic [ADDR_W-1:0]             cfg_base,
  input  logic [ADDR_W-1:0]             cfg_stride,
  input  logic [ADDR_W-1:0]             cfg_step,
  input  logic                          advance,
  output logic [LANES-1:0][ADDR_W-1:0]  lane_addr
);
  logic [ADDR_W-1:0] base_q, stride_q, step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      stride_q <= '0;
      step_q   <= '0;
    end else if (cfg_load) begin
      base_q   <= cfg_base;
      stride_q <= cfg_stride;
      step_q   <= cfg_step;
    end else if (advance) begin
      base_q   <= base_q + step_q;
    end
  end

  // Per-lane address, wrapping at the depth through truncation.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = base_q + stride_q * ADDR_W'(g);
  end

  assert_load_base_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (base_q == $past(cfg_base) && stride_q == $past(cfg_stride)));

  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_load && advance) |=> (base_q == $past(base_q + step_q) && $stable(stride_q)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_load && !advance) |=> $stable(base_q));
endmodule

// File: rtl/lane_stride_store.sv
module lane_stride_store #(
  parameter int LANES  = 16,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
  input  logic [LANES-1:0][WORD_W-1:0]  wr_vec,
  output logic [LANES-1:0][WORD_W-1:0]  rd_vec,
  output logic                          rd_valid
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Scatter: later lanes override earlier ones on a shared address.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        mem[lane_addr[i]] <= wr_vec[i];
      end
    end
  end

  // Gather into a registered output.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_vec   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        for (int i = 0; i < LANES; i++) begin
          rd_vec[i] <= mem[lane_addr[i]];
        end
      end
    end
  end

  assert_read_valid_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_vec)));
endmodule

// File: rtl/lane_stride_mem.sv
module lane_stride_mem
  import lane_stride_pkg::*;
#(
  parameter  int LANES  = 16,
  parameter  int WORD_W = 32,
  parameter  int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_load,
  input  logic [ADDR_W-1:0]        cfg_base,
  input  logic [ADDR_W-1:0]        cfg_stride,
  input  logic [ADDR_W-1:0]        cfg_step,
  input  logic                     rd_req,
  input  logic                     wr_req,
  input  logic [LANES*WORD_W-1:0]  wr_data,
  output logic [LANES*WORD_W-1:0]  rd_data,
  output logic                     rd_valid
);
  lane_op_e                       op;
  logic [LANES-1:0][ADDR_W-1:0]   lane_addr;
  logic [LANES-1:0][WORD_W-1:0]   wr_vec;
  logic [LANES-1:0][WORD_W-1:0]   rd_vec;

  assign wr_vec  = wr_data;
  assign rd_data = rd_vec;

  lane_stride_arb u_arb (
    .clk    (clk),
    .rst    (rst),
    .rd_req (rd_req),
    .wr_req (wr_req),
    .op     (op)
  );

  lane_stride_addr #(.LANES(LANES), .ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .cfg_base   (cfg_base),
    .cfg_stride (cfg_stride),
    .cfg_step   (cfg_step),
    .advance    (op != OP_IDLE),
    .lane_addr  (lane_addr)
  );

  lane_stride_store #(.LANES(LANES), .WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (op == OP_WRITE),
    .rd_en     (op == OP_READ),
    .lane_addr (lane_addr),
    .wr_vec    (wr_vec),
    .rd_vec    (rd_vec),
    .rd_valid  (rd_valid)
  );

  // R5: a lone read request produces valid data on the next edge
  assert_lone_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req) |=> rd_valid);

  // R6: no data is returned in the cycle after a write
  assert_no_data_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !rd_valid);
endmodule

// File: tb/lane_stride_mem_test.sv
`timescale 1ns/1ps
module lane_stride_mem_test;
  localparam int LANES  = 16;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int VW     = LANES * WORD_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0, cfg_stride = '0, cfg_step = '0;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic [VW-1:0] wr_data = '0;
  logic [VW-1:0] rd_data;
  logic rd_valid;

  always #4 clk = ~clk;

  lane_stride_mem #(.LANES(LANES), .WORD_W(WORD_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_stride(cfg_stride), .cfg_step(cfg_step), .rd_req(rd_req),
    .wr_req(wr_req), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [WORD_W-1:0] m_mem [DEPTH];
  int m_base = 0, m_stride = 0, m_step = 0;
  bit m_held = 0;
  bit exp_valid = 0;
  logic [VW-1:0] exp_vec = '0;
  string exp_tag = "R7";
  logic [VW-1:0] wvec = '0;

  function automatic int lane_at(int i);
    return (m_base + i * m_stride) & (DEPTH - 1);
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*WORD_W +: WORD_W] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_outputs();
    chk(rd_valid == exp_valid, "R5 valid strobe", VW'(rd_valid), VW'(exp_valid));
    chk(rd_data == exp_vec, exp_valid ? exp_tag : "R5 hold", rd_data, exp_vec);
  endtask

  // One clock cycle: check previous results, drive inputs, advance model.
  task automatic step(input bit ld, input int b, input int s, input int t,
                      input bit rd, input bit wr, input string tag);
    bit rx;
    @(negedge clk);
    check_outputs();
    cfg_load   = ld;
    cfg_base   = ADDR_W'(b);
    cfg_stride = ADDR_W'(s);
    cfg_step   = ADDR_W'(t);
    rd_req     = rd;
    wr_req     = wr;
    wr_data    = wvec;
    rx     = !wr && (rd || m_held);
    m_held = wr && (rd || m_held);
    exp_valid = rx;
    if (rx) begin
      for (int i = 0; i < LANES; i++) exp_vec[i*WORD_W +: WORD_W] = m_mem[lane_at(i)];
      exp_tag = tag;
    end
    if (wr) for (int i = 0; i < LANES; i++) m_mem[lane_at(i)] = wvec[i*WORD_W +: WORD_W];
    if (ld) begin
      m_base = b & (DEPTH - 1); m_stride = s & (DEPTH - 1); m_step = t & (DEPTH - 1);
    end else if (rx || wr) begin
      m_base = (m_base + m_step) & (DEPTH - 1);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic setup(input int b, input int s, input int t);
    step(1, b, s, t, 0, 0, "R4");
  endtask

  initial begin
    void'($urandom(32'd20240211));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset outputs, and zero base/stride/step put every lane on address 0
    idle("R7");
    wvec = rand_vec();
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, 0, "R7 zero pointer after reset");
    idle("R7");
    // fill the whole store with known data
    setup(0, 1, LANES);
    for (int k = 0; k < DEPTH / LANES; k++) begin
      wvec = rand_vec();
      step(0, 0, 0, 0, 0, 1, "R2");
    end
    // R1 gather, R3 advance
    setup(5, 7, 3);
    step(0, 0, 0, 0, 1, 0, "R1 gather");
    step(0, 0, 0, 0, 1, 0, "R3 advanced gather");
    wvec = rand_vec();
    step(0, 0, 0, 0, 0, 1, "R2");
    setup(11, 7, 3);
    step(0, 0, 0, 0, 1, 0, "R2 scatter readback");
    // R2 collision: stride 0 keeps lane 15
    setup(40, 0, 1);
    wvec = rand_vec();
    step(0, 0, 0, 0, 0, 1, "R2");
    setup(40, 1, 0);
    step(0, 0, 0, 0, 1, 0, "R2 colliding lanes");
    // R8 wrap
    setup(250, 3, 9);
    wvec = rand_vec();
    step(0, 0, 0, 0, 0, 1, "R8");
    setup(250, 3, 9);
    step(0, 0, 0, 0, 1, 0, "R8 wrap readback");
    step(0, 0, 0, 0, 1, 0, "R8 wrapped base");
    // R4: setup concurrent with a read
    step(1, 100, 2, 5, 1, 0, "R4 read with old settings");
    step(0, 0, 0, 0, 1, 0, "R4 read at loaded base");
    // R6: collision, then collision followed by another write
    wvec = rand_vec();
    step(0, 0, 0, 0, 1, 1, "R6");
    idle("R6 held read");
    idle("R6");
    wvec = rand_vec();
    step(0, 0, 0, 0, 1, 1, "R6");
    wvec = rand_vec();
    step(0, 0, 0, 0, 0, 1, "R6");
    idle("R6 held read after two writes");
    idle("R6");
    // constrained random phase
    for (int k = 0; k < 600; k++) begin
      bit ld, rd, wr;
      ld = ($urandom % 16) == 0;
      rd = !m_held && ($urandom % 2 == 0);
      wr = ($urandom % 3) == 0;
      wvec = rand_vec();
      step(ld, int'($urandom % DEPTH), int'($urandom % DEPTH), int'($urandom % DEPTH),
           rd, wr, "R1 R3 random");
    end
    idle("R5");
    idle("R5");
    idle("R5");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule